// File: doc/BRIEF.md
# JTAG Boundary Scan Data Registers

This block holds the data-side registers that sit behind a JTAG test access port of a memory device. There are three of them: a boundary scan chain, a 32-bit identification register and a single-bit bypass register. The TAP state machine lives elsewhere and hands this block one-cycle strobes for the capture, shift and update phases of a data-register scan, together with the current instruction code. The instruction decoder inside the block picks one register. Only that register captures and shifts, and its least significant bit is driven toward TDO.

The boundary chain holds two kinds of cell. Pin cells sample the level present on their device pin. Placeholder cells always load a logic 1. A parameter mask states which chain index is which kind. A parallel update latch takes a copy of the chain during the update phase and presents it to the pad logic for external-drive and high-impedance sampling use. The latch keeps its value while a new pattern is being shifted in. All registers are clocked on the rising edge of TCK. The TDO bit is re-timed on the falling edge.

Top module: `jtag_test_data_regs`

## Requirements
- R1: While `trst_n` is low, `tdo` is 0 and every bit of `bs_update` is 0.
- R2: The boundary chain is selected by instruction codes 3'b000 (external drive), 3'b010 (sample/preload) and 3'b011 (sample with outputs high-impedance). When `cap_dr` is high at a rising TCK edge, each pin cell i (a cell whose `HOLD_MASK` bit is 0) loads `pins[i]`.
- R3: At the same capture edge, each placeholder cell (a cell whose `HOLD_MASK` bit is 1) loads 1, whatever value is on `pins`.
- R4: With the chain selected and `shift_dr` high, each rising edge moves the chain one place toward index 0 and loads `tdi` into index CHAIN_LEN-1. Index 0 is the bit presented on TDO, so bit 0 leaves first.
- R5: Under instruction 3'b001 (identify), a capture loads the constant {version[3:0], part[15:0], maker[10:0], 1'b1}. Shifting then presents bit 0 first, and `tdi` enters at bit 31.
- R6: Instruction 3'b111 and every code not listed in R2 or R5 selects the bypass register. It captures 0, and during a shift it delays `tdi` by exactly one TCK.
- R7: `tdo` equals bit 0 of the selected register, and it is updated only on falling TCK edges. It never changes at a rising edge.
- R8: `bs_update` loads the chain contents when `update_dr` is high at a rising edge while the chain is selected. It holds its value across capture, shift, and any update under a non-chain instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| cap_dr | input | 1 | Capture phase strobe from the TAP |
| shift_dr | input | 1 | Shift phase strobe from the TAP |
| update_dr | input | 1 | Update phase strobe from the TAP |
| instr | input | 3 | Current instruction code |
| pins | input | CHAIN_LEN | Pin levels offered to the chain cells |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| bs_update | output | CHAIN_LEN | Parallel update latch of the chain |

## Verification
The chain is captured with alternating, all-zero and all-one pin patterns. The all-zero pattern separates a placeholder that is truly held at 1 from a pin cell that happens to see a 1, and the all-one pattern exposes a pin cell that is stuck at 0. Shifting a known pattern through each register and reading the tdo sequence back shows the scan order and the register length. The same pattern is used to tell the identification constant apart from the bypass one-cycle delay. An update issued under a non-chain instruction, and the shifts that follow an update, show whether the update latch holds its value.

// File: rtl/jtag_tdr_pkg.sv
package jtag_tdr_pkg;
    localparam int unsigned JT_IR_W = 3;
    localparam logic [JT_IR_W-1:0] OP_EXT_DRIVE = 3'b000;
    localparam logic [JT_IR_W-1:0] OP_IDENTIFY  = 3'b001;
    localparam logic [JT_IR_W-1:0] OP_SAMPLE    = 3'b010;
    localparam logic [JT_IR_W-1:0] OP_SAMPLE_HZ = 3'b011;
    localparam logic [JT_IR_W-1:0] OP_BYPASS    = 3'b111;

    typedef enum logic [1:0] {
        DR_BYPASS   = 2'd0,
        DR_IDENT    = 2'd1,
        DR_BOUNDARY = 2'd2
    } dr_sel_e;

    function automatic dr_sel_e decode_dr(input logic [JT_IR_W-1:0] code);
        dr_sel_e s;
        unique case (code)
            OP_EXT_DRIVE, OP_SAMPLE, OP_SAMPLE_HZ: s = DR_BOUNDARY;
            OP_IDENTIFY:                           s = DR_IDENT;
            default:                               s = DR_BYPASS;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain #(
    parameter int unsigned LEN = 12,
    parameter logic [LEN-1:0] HOLD_MASK = '0
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           sel,
    input  logic           cap,
    input  logic           shft,
    input  logic           upd,
    input  logic           tdi,
    input  logic [LEN-1:0] pins,
    output logic [LEN-1:0] chain_q,
    output logic [LEN-1:0] upd_q
);
    logic [LEN-1:0] cap_val;
    logic [LEN-1:0] shift_in;

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        if (HOLD_MASK[i]) begin : g_hold
            assign cap_val[i] = 1'b1;
        end else begin : g_pin
            assign cap_val[i] = pins[i];
        end

        if (i == LEN - 1) begin : g_head
            assign shift_in[i] = tdi;
        end else begin : g_link
            assign shift_in[i] = chain_q[i+1];
        end

        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n) begin
                chain_q[i] <= 1'b0;
            end else if (sel && cap) begin
                chain_q[i] <= cap_val[i];
            end else if (sel && shft) begin
                chain_q[i] <= shift_in[i];
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_q <= '0;
        end else if (sel && upd) begin
            upd_q <= chain_q;
        end
    end
endmodule

// File: rtl/jtag_id_reg.sv
module jtag_id_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] ID_VALUE = 32'h1
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         sel,
    input  logic         cap,
    input  logic         shft,
    input  logic         tdi,
    output logic [W-1:0] id_q
);
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_q <= '0;
        end else if (sel && cap) begin
            id_q <= ID_VALUE;
        end else if (sel && shft) begin
            id_q <= {tdi, id_q[W-1:1]};
        end
    end
endmodule

// File: rtl/jtag_bypass_reg.sv
module jtag_bypass_reg (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic cap,
    input  logic shft,
    input  logic tdi,
    output logic byp_q
);
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (sel && cap) begin
            byp_q <= 1'b0;
        end else if (sel && shft) begin
            byp_q <= tdi;
        end
    end
endmodule

// File: rtl/jtag_test_data_regs.sv
module jtag_test_data_regs
    import jtag_tdr_pkg::*;
#(
    parameter int unsigned CHAIN_LEN = 12,
    parameter logic [CHAIN_LEN-1:0] HOLD_MASK = 12'h821,
    parameter logic [3:0]  ID_VER  = 4'h2,
    parameter logic [15:0] ID_PART = 16'h5A3C,
    parameter logic [10:0] ID_MFR  = 11'h0B7
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 cap_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic [JT_IR_W-1:0]   instr,
    input  logic [CHAIN_LEN-1:0] pins,
    output logic                 tdo,
    output logic [CHAIN_LEN-1:0] bs_update
);
    localparam int unsigned ID_W = 32;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VER, ID_PART, ID_MFR, 1'b1};

    dr_sel_e             sel;
    logic [CHAIN_LEN-1:0] bs_q;
    logic [ID_W-1:0]      id_q;
    logic                 byp_q;
    logic                 tdo_d;

    always_comb begin
        sel = decode_dr(instr);
    end

    jtag_bscan_chain #(
        .LEN       (CHAIN_LEN),
        .HOLD_MASK (HOLD_MASK)
    ) u_chain (
        .tck     (tck),
        .trst_n  (trst_n),
        .sel     (sel == DR_BOUNDARY),
        .cap     (cap_dr),
        .shft    (shift_dr),
        .upd     (update_dr),
        .tdi     (tdi),
        .pins    (pins),
        .chain_q (bs_q),
        .upd_q   (bs_update)
    );

    jtag_id_reg #(
        .W        (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_ident (
        .tck    (tck),
        .trst_n (trst_n),
        .sel    (sel == DR_IDENT),
        .cap    (cap_dr),
        .shft   (shift_dr),
        .tdi    (tdi),
        .id_q   (id_q)
    );

    jtag_bypass_reg u_bypass (
        .tck    (tck),
        .trst_n (trst_n),
        .sel    (sel == DR_BYPASS),
        .cap    (cap_dr),
        .shft   (shift_dr),
        .tdi    (tdi),
        .byp_q  (byp_q)
    );

    // Output mux: bit 0 of the selected register
    always_comb begin
        unique case (sel)
            DR_BOUNDARY: tdo_d = bs_q[0];
            DR_IDENT:    tdo_d = id_q[0];
            DR_BYPASS:   tdo_d = byp_q;
            default:     tdo_d = byp_q;
        endcase
    end

    // R7: falling-edge retiming of the serial output
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo <= 1'b0;
        end else begin
            tdo <= tdo_d;
        end
    end
endmodule

// File: rtl/jtag_tdr_checker.sv
module jtag_tdr_checker
    import jtag_tdr_pkg::*;
#(
    parameter int unsigned LEN = 12,
    parameter logic [LEN-1:0] HOLD_MASK = '0,
    parameter logic [31:0] ID_VALUE = 32'h1
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tdi,
    input logic               cap_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic [JT_IR_W-1:0] instr,
    input logic [LEN-1:0]     pins,
    input logic               tdo,
    input logic [LEN-1:0]     bs_update,
    input logic [LEN-1:0]     bs_q,
    input logic [31:0]        id_q,
    input logic               byp_q
);
    logic chain_op;
    assign chain_op = (instr == OP_EXT_DRIVE) || (instr == OP_SAMPLE) || (instr == OP_SAMPLE_HZ);

    a_r1_reset_quiet: assert property (@(posedge tck)
        !trst_n |-> (bs_update == '0 && tdo == 1'b0));

    a_r2_pin_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && chain_op) |=> ((bs_q & ~HOLD_MASK) == ($past(pins) & ~HOLD_MASK)));

    a_r3_holder_ones: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && chain_op) |=> ((bs_q & HOLD_MASK) == HOLD_MASK));

    a_r4_shift_entry: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !cap_dr && chain_op) |=> (bs_q[LEN-1] == $past(tdi)));

    a_r5_id_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && instr == OP_IDENTIFY) |=> (id_q == ID_VALUE));

    a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && !chain_op && instr != OP_IDENTIFY) |=> (byp_q == 1'b0));

    a_r8_latch_hold: assert property (@(posedge tck) disable iff (!trst_n)
        !(update_dr && chain_op) |=> $stable(bs_update));
endmodule

bind jtag_test_data_regs jtag_tdr_checker #(
    .LEN       (CHAIN_LEN),
    .HOLD_MASK (HOLD_MASK),
    .ID_VALUE  (ID_VALUE)
) i_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .cap_dr    (cap_dr),
    .shift_dr  (shift_dr),
    .update_dr (update_dr),
    .instr     (instr),
    .pins      (pins),
    .tdo       (tdo),
    .bs_update (bs_update),
    .bs_q      (bs_q),
    .id_q      (id_q),
    .byp_q     (byp_q)
);

// File: tb/test_jtag_test_data_regs.sv
`timescale 1ns/1ps
module test_jtag_test_data_regs;
    localparam int N = 12;
    localparam logic [N-1:0] MASK = 12'h821;
    localparam logic [31:0] ID_EXP = {4'h2, 16'h5A3C, 11'h0B7, 1'b1};

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [2:0] instr = 3'b111;
    logic [N-1:0] pins = '0;
    logic tdo;
    logic [N-1:0] bs_update;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [N-1:0] m_bs = '0, m_upd = '0;
    logic [31:0]  m_id = '0;
    logic         m_byp = 1'b0, m_tdo = 1'b0;

    always #2 tck = ~tck;

    jtag_test_data_regs i_jtag_test_data_regs (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .instr(instr),
        .pins(pins), .tdo(tdo), .bs_update(bs_update)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 bypass, 1 ident, 2 chain: codes from R2, R5, R6
    function automatic int pick(input logic [2:0] c);
        if (c == 3'b000 || c == 3'b010 || c == 3'b011) return 2;
        if (c == 3'b001) return 1;
        return 0;
    endfunction

    // one TCK cycle with reference comparison on both edges
    task automatic cyc(input logic c, input logic s, input logic u,
                       input logic [2:0] ins, input logic d, input logic [N-1:0] p);
        logic [N-1:0] old_bs;
        int k;
        cap_dr = c; shift_dr = s; update_dr = u; instr = ins; tdi = d; pins = p;
        k = pick(ins);
        @(posedge tck);
        old_bs = m_bs;
        if (k == 2) begin
            if (u) m_upd = old_bs;
            if (c) m_bs = (p & ~MASK) | MASK;
            else if (s) m_bs = {d, old_bs[N-1:1]};
        end else if (k == 1) begin
            if (c) m_id = ID_EXP;
            else if (s) m_id = {d, m_id[31:1]};
        end else begin
            if (c) m_byp = 1'b0;
            else if (s) m_byp = d;
        end
        #1;
        check("R7 tdo held at rising edge", {31'd0, tdo}, {31'd0, m_tdo});
        check("R8 update latch", {{(32-N){1'b0}}, bs_update}, {{(32-N){1'b0}}, m_upd});
        @(negedge tck);
        m_tdo = (k == 2) ? m_bs[0] : (k == 1) ? m_id[0] : m_byp;
        #1;
        check("R7 tdo follows selected bit 0", {31'd0, tdo}, {31'd0, m_tdo});
    endtask

    // capture then shift LEN bits, returning what appeared on tdo
    task automatic scan(input logic [2:0] ins, input int len, input logic [31:0] din,
                        input logic [N-1:0] p, output logic [31:0] dout);
        dout = '0;
        cyc(1, 0, 0, ins, 0, p);
        dout[0] = tdo;
        for (int i = 0; i < len; i++) begin
            cyc(0, 1, 0, ins, din[i], p);
            if (i + 1 < len) dout[i+1] = tdo;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge tck);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        // R1: reset state
        repeat (3) @(posedge tck);
        #1;
        check("R1 tdo in reset", {31'd0, tdo}, 32'd0);
        check("R1 update latch in reset", {{(32-N){1'b0}}, bs_update}, 32'd0);
        @(negedge tck);
        trst_n = 1'b1;
        cyc(0, 0, 0, 3'b111, 0, '0);

        // R2/R3/R4: sample/preload with alternating pins
        scan(3'b010, N, 32'h0000_0C35, 12'hA5A, got);
        check("R2 R3 R4 chain readout alternating", got & 32'hFFF, {20'd0, (12'hA5A & ~MASK) | MASK});
        // R8: update copies the shifted-in pattern
        cyc(0, 0, 1, 3'b010, 0, '0);
        check("R8 latch after update", {20'd0, bs_update}, 32'h0000_0C35);
        // R3: all-zero pins, holders still 1; latch holds during shift (R8)
        scan(3'b000, N, 32'h0, '0, got);
        check("R3 holders with pins low", got & 32'hFFF, {20'd0, MASK});
        check("R8 latch held over shift", {20'd0, bs_update}, 32'h0000_0C35);
        // R2: all-one pins under the high-impedance sample code
        scan(3'b011, N, 32'h0000_0FFF, '1, got);
        check("R2 pins high under sample-hz", got & 32'hFFF, 32'h0000_0FFF);

        // R5: identification readout
        scan(3'b001, 32, 32'hDEAD_BEEF, '0, got);
        check("R5 id constant lsb first", got, ID_EXP);
        cyc(0, 0, 1, 3'b001, 0, '0);
        check("R8 update under identify ignored", {20'd0, bs_update}, 32'h0000_0C35);

        // R6: bypass and an unlisted code, one-cycle delay
        for (int v = 0; v < 2; v++) begin
            logic [2:0] code;
            code = (v == 0) ? 3'b111 : 3'b101;
            scan(code, 6, 32'h0000_002D, '0, got);
            check("R6 bypass capture zero then delayed tdi", got & 32'h3F, 32'h0000_001A);
        end

        // R4: sustained shift through the chain with external-drive code
        scan(3'b000, N, 32'h0000_0933, 12'h3C3, got);
        cyc(0, 0, 1, 3'b000, 0, '0);
        check("R4 R8 shifted word lands in latch", {20'd0, bs_update}, 32'h0000_0933);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule